// File: doc/BRIEF.md
# Binary Tap Divider with Watchdog Supervisor

This block divides a base timing strobe through a chain of fifteen toggle stages. Each stage flips when the stage below it falls from high to low, so the chain offers fifteen binary taps. The taps give slow periodic rates to timers, debouncers and display logic. The design is fully synchronous. One system clock runs the whole block, the input `ph0Tick` marks each falling edge of the base rate, and every stage toggle is a clock enable. The upper stages can be forced low by a command or by a pin reset. A falling edge of one high stage produces a one-cycle wake pulse that releases a halted processor.

The same block supervises the software. A watchdog counter advances on each falling edge of a chosen tap while software keeps it enabled. If software fails to restart the counter within the selected window, the block issues a fixed-length device reset request. The block also records that the watchdog caused that reset. The enable flag is deliberately left alone by the watchdog's own reset, so supervision continues after recovery. Only a power-on reset or the external pin reset turns it off.

Top module: `tick_chain_wdog`

## Requirements
- R1: `taps` (bit k = stage k) holds the number of `ph0Tick` cycles since power-on reset, modulo 2^15. Stage 1 toggles on every tick and stage k toggles when stage k-1 falls. With `ph0Tick` low, `taps` does not change.
- R2: `divClr` forces stages 11 to 15 low at the next edge while stages 1 to 10 still count. A fall of stage 14 that the clear causes or overrides raises no wake pulse.
- R3: `rstN` low clears every stage, flag and counter. `extRst` high forces stages 11 to 15 low, clears `wdEn` and `wdFlag`, and ends any `rstReq` pulse at the next edge.
- R4: `wakePulse` is high for exactly one cycle, in the cycle right after the edge at which stage 14 falls through counting.
- R5: While enabled, the watchdog counts falling edges of stage WD_TAP (default 10). The window is set by `wdSpan`: 0 gives 8 falls, 1 gives 64, and 2 or 3 give 512. The terminal fall is the last fall of the window.
- R6: The terminal fall starts a `rstReq` pulse of RST_LEN (default 4) cycles, beginning the cycle after that edge.
- R7: A watchdog reset sets `wdFlag` and leaves `wdEn` set. The count restarts from zero, so the next window begins once the pulse ends.
- R8: `wdKick` restarts the count. A kick in the same cycle as the terminal fall wins, and no reset is issued.
- R9: `wdEnSet` sets and `wdEnClr` clears `wdEn`. When both are pulsed together, clear wins. Clearing the enable also zeroes the count, and a disabled watchdog never requests a reset.
- R10: `flagClr` clears `wdFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on reset, asynchronous, active low |
| extRst | input | 1 | External pin reset, synchronous, active high |
| ph0Tick | input | 1 | One-cycle strobe per falling edge of the base rate |
| wdSpan | input | 2 | Watchdog window select (0: 8, 1: 64, 2/3: 512 tap falls) |
| divClr | input | 1 | Force the upper stages low |
| wdEnSet | input | 1 | Enable the watchdog |
| wdEnClr | input | 1 | Disable the watchdog |
| wdKick | input | 1 | Restart the watchdog count |
| flagClr | input | 1 | Clear the watchdog-reset status |
| taps | output | 15 | Stage outputs, bit k is stage k |
| wakePulse | output | 1 | Halt-release pulse from stage 14 falling |
| rstReq | output | 1 | Device reset request from the watchdog |
| wdEn | output | 1 | Watchdog enable flag |
| wdFlag | output | 1 | Last reset came from the watchdog |

## Verification
Two pairs of events can land on the same edge. The first is the stage-14 fall that would raise a wake pulse, set against an upper-stage clear. The second is the terminal watchdog fall, set against a software kick. For the first pair, the chain is run from power-on to the count just below the fall and `divClr` is pulsed on the edge that would roll stage 14. The check is that all taps read zero and no wake appears. For the second pair, the kick is timed to the edge of the eighth watched fall. The check is that no reset request appears there, and that one appears exactly one full window later.

// File: rtl/tcw_pkg.sv
`timescale 1ns/1ps
package tcw_pkg;
  // Each window option multiplies the window length by 2^SPAN_LOG_STEP.
  localparam int SPAN_LOG_STEP = 3;
  localparam int SPAN_OPTS     = 3;
  localparam int WD_W          = SPAN_LOG_STEP * SPAN_OPTS;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clrUpper;  // force upper stages low
    logic wdRun;     // watchdog may count
    logic wdClr;     // watchdog count to zero
  } tcwStrobe_t;
endpackage

// File: rtl/tcw_datapath.sv
`timescale 1ns/1ps
module tcw_datapath
  import tcw_pkg::*;
#(
  parameter int STAGES   = 15,
  parameter int CLR_LO   = 11,
  parameter int WAKE_TAP = 14,
  parameter int WD_TAP   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ph0Tick,
  input  logic [1:0]        wdSpan,
  input  tcwStrobe_t        strobe,
  output logic [STAGES:1]   taps,
  output logic              wakePulse,
  output logic              wdTerm
);
  localparam bit WAKE_IN_CLR = (WAKE_TAP >= CLR_LO);

  logic [STAGES:1] stage, stageNxt, toggle, fallEv;
  logic [WD_W-1:0] wdCnt, termVal;
  logic [1:0]      spanSel;
  logic            wakeQ;

  // Stage k toggles when all lower stages are high on a tick; it falls when it is high too.
  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    if (k == 1) begin : g_first
      assign toggle[k] = ph0Tick;
    end else begin : g_rest
      assign toggle[k] = ph0Tick & (&stage[k-1:1]);
    end
    assign fallEv[k] = toggle[k] & stage[k];
    if (k >= CLR_LO) begin : g_clr
      assign stageNxt[k] = strobe.clrUpper ? 1'b0 : (stage[k] ^ toggle[k]);
    end else begin : g_keep
      assign stageNxt[k] = stage[k] ^ toggle[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
      wakeQ <= 1'b0;
    end else begin
      stage <= stageNxt;
      wakeQ <= fallEv[WAKE_TAP] & ~(strobe.clrUpper & WAKE_IN_CLR);
    end
  end

  // Window end value: 2^(3*(sel+1)) - 1, with select 3 folded onto 2.
  always_comb begin
    spanSel = (wdSpan == 2'd3) ? 2'd2 : wdSpan;
    termVal = WD_W'((32'd1 << (SPAN_LOG_STEP * (32'(spanSel) + 32'd1))) - 32'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                wdCnt <= '0;
    else if (strobe.wdClr)                    wdCnt <= '0;
    else if (strobe.wdRun && fallEv[WD_TAP])  wdCnt <= wdCnt + 1'b1;
  end

  assign wdTerm    = strobe.wdRun & fallEv[WD_TAP] & (wdCnt == termVal);
  assign taps      = stage;
  assign wakePulse = wakeQ;
endmodule

// File: rtl/tcw_ctrl.sv
`timescale 1ns/1ps
module tcw_ctrl
  import tcw_pkg::*;
#(
  parameter int RST_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extRst,
  input  logic       divClr,
  input  logic       wdEnSet,
  input  logic       wdEnClr,
  input  logic       wdKick,
  input  logic       flagClr,
  input  logic       wdTerm,
  output tcwStrobe_t strobe,
  output logic       wdEn,
  output logic       wdFlag,
  output logic       rstReq
);
  localparam int RC_W = $clog2(RST_LEN + 1);

  logic [RC_W-1:0] rstCnt;
  logic            fire, pulsing;

  assign pulsing = (rstCnt != '0);
  // Kick, disable and pin reset all override a terminal fall.
  assign fire    = wdTerm & ~wdKick & ~wdEnClr & ~extRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdEn   <= 1'b0;
      wdFlag <= 1'b0;
      rstCnt <= '0;
    end else if (extRst) begin
      wdEn   <= 1'b0;
      wdFlag <= 1'b0;
      rstCnt <= '0;
    end else begin
      if (wdEnClr)      wdEn <= 1'b0;
      else if (wdEnSet) wdEn <= 1'b1;
      if (fire)         wdFlag <= 1'b1;
      else if (flagClr) wdFlag <= 1'b0;
      if (fire)         rstCnt <= RC_W'(RST_LEN);
      else if (pulsing) rstCnt <= rstCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.clrUpper = divClr | extRst;
    strobe.wdRun    = wdEn & ~pulsing;
    strobe.wdClr    = extRst | wdKick | wdEnClr | fire | pulsing;
  end

  assign rstReq = pulsing;
endmodule

// File: rtl/tick_chain_wdog.sv
`timescale 1ns/1ps
module tick_chain_wdog
  import tcw_pkg::*;
#(
  parameter int STAGES   = 15,
  parameter int CLR_LO   = 11,
  parameter int WAKE_TAP = 14,
  parameter int WD_TAP   = 10,
  parameter int RST_LEN  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extRst,
  input  logic              ph0Tick,
  input  logic [1:0]        wdSpan,
  input  logic              divClr,
  input  logic              wdEnSet,
  input  logic              wdEnClr,
  input  logic              wdKick,
  input  logic              flagClr,
  output logic [STAGES:1]   taps,
  output logic              wakePulse,
  output logic              rstReq,
  output logic              wdEn,
  output logic              wdFlag
);
  tcwStrobe_t strobe;
  logic       wdTerm;

  tcw_ctrl #(.RST_LEN(RST_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .extRst(extRst), .divClr(divClr),
    .wdEnSet(wdEnSet), .wdEnClr(wdEnClr), .wdKick(wdKick), .flagClr(flagClr),
    .wdTerm(wdTerm), .strobe(strobe), .wdEn(wdEn), .wdFlag(wdFlag), .rstReq(rstReq)
  );

  tcw_datapath #(
    .STAGES(STAGES), .CLR_LO(CLR_LO), .WAKE_TAP(WAKE_TAP), .WD_TAP(WD_TAP)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ph0Tick(ph0Tick), .wdSpan(wdSpan), .strobe(strobe),
    .taps(taps), .wakePulse(wakePulse), .wdTerm(wdTerm)
  );
endmodule

// File: rtl/tcw_checker.sv
`timescale 1ns/1ps
module tcw_checker #(
  parameter int STAGES   = 15,
  parameter int CLR_LO   = 11,
  parameter int WAKE_TAP = 14
) (
  input logic            clk,
  input logic            rstN,
  input logic            extRst,
  input logic            ph0Tick,
  input logic            divClr,
  input logic            wdEnClr,
  input logic [STAGES:1] taps,
  input logic            wakePulse,
  input logic            rstReq,
  input logic            wdEn,
  input logic            wdFlag
);
  AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ph0Tick && !divClr && !extRst) |=> $stable(taps)); // R1
  AST_UPPER_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    divClr |=> (taps[STAGES:CLR_LO] == '0)); // R2
  AST_PIN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    extRst |=> (!wdEn && !wdFlag && !rstReq)); // R3
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse); // R4
  AST_WAKE_TAP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> !taps[WAKE_TAP]); // R4
  AST_FIRE_KEEPS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> wdEn); // R7
  AST_FIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> wdFlag); // R7
  AST_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    wdEnClr |=> !wdEn); // R9
endmodule

bind tick_chain_wdog tcw_checker #(
  .STAGES(STAGES), .CLR_LO(CLR_LO), .WAKE_TAP(WAKE_TAP)
) chk_i (
  .clk(clk), .rstN(rstN), .extRst(extRst), .ph0Tick(ph0Tick), .divClr(divClr),
  .wdEnClr(wdEnClr), .taps(taps), .wakePulse(wakePulse), .rstReq(rstReq),
  .wdEn(wdEn), .wdFlag(wdFlag)
);

// File: tb/tick_chain_wdog_tb_top.sv
`timescale 1ns/1ps
module tick_chain_wdog_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, extRst, ph0Tick, divClr, wdEnSet, wdEnClr, wdKick, flagClr;
  logic [1:0]  wdSpan;
  logic [15:1] taps;
  logic        wakePulse, rstReq, wdEn, wdFlag;
  int nChk = 0, nBad = 0, fe = 0, hiLen = 0;
  bit done = 1'b0;

  // Watched tap lowered to stage 4 so that the 512 window fits the run.
  tick_chain_wdog #(.WD_TAP(4)) dut_i (
    .clk(clk), .rstN(rstN), .extRst(extRst), .ph0Tick(ph0Tick), .wdSpan(wdSpan),
    .divClr(divClr), .wdEnSet(wdEnSet), .wdEnClr(wdEnClr), .wdKick(wdKick),
    .flagClr(flagClr), .taps(taps), .wakePulse(wakePulse), .rstReq(rstReq),
    .wdEn(wdEn), .wdFlag(wdFlag)
  );

  // {tick enable, cycles, expected taps}
  localparam int VEC_N = 7;
  localparam logic [31:0] VEC [VEC_N] = '{
    {1'b1, 16'd1,    15'd1},
    {1'b1, 16'd7,    15'd8},
    {1'b1, 16'd120,  15'd128},
    {1'b0, 16'd50,   15'd128},
    {1'b1, 16'd896,  15'd1024},
    {1'b1, 16'd1023, 15'd2047},
    {1'b1, 16'd1,    15'd2048}
  };

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic por();
    rstN = 1'b0; extRst = 1'b0; divClr = 1'b0; wdEnSet = 1'b0; wdEnClr = 1'b0;
    wdKick = 1'b0; flagClr = 1'b0; ph0Tick = 1'b1;
    step(); step();
    rstN = 1'b1;
  endtask

  // Power-on, enable at edge 1, optional kick/disable edges; returns edge of first rstReq.
  task automatic wdRun(input logic [1:0] sp, input int kickE, input int offE,
                       input int lim, output int fireE);
    por();
    wdSpan = sp;
    fireE = -1;
    for (int e = 1; e <= lim; e++) begin
      wdEnSet = (e == 1);
      wdKick  = (e == kickE);
      wdEnClr = (e == offE);
      step();
      if (rstReq && fireE < 0) begin
        fireE = e;
        break;
      end
    end
    wdEnSet = 1'b0; wdKick = 1'b0; wdEnClr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL R1 timeout: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    wdSpan = 2'd0;
    por();
    // R3: state after power-on reset
    check("R3 taps after POR", int'(taps), 0);
    check("R3 wdEn after POR", int'(wdEn), 0);
    check("R3 wdFlag after POR", int'(wdFlag), 0);
    check("R3 rstReq after POR", int'(rstReq), 0);

    // R1: table of tick runs
    for (int i = 0; i < VEC_N; i++) begin
      ph0Tick = VEC[i][31];
      repeat (int'(VEC[i][30:15])) step();
      check("R1 count", int'(taps), int'(VEC[i][14:0]));
    end

    // R2: clear upper stages, lower kept
    ph0Tick = 1'b1;
    repeat (100) step();
    ph0Tick = 1'b0; divClr = 1'b1; step(); divClr = 1'b0;
    check("R2 upper cleared", int'(taps), 100);

    // R4: wake pulse on stage 14 fall
    por();
    repeat (16383) step();
    check("R4 no wake before fall", int'(wakePulse), 0);
    step();
    check("R4 wake at fall", int'(wakePulse), 1);
    check("R1 count at 16384", int'(taps), 16384);
    step();
    check("R4 wake one cycle", int'(wakePulse), 0);

    // R2/R4: clear on the edge of the stage 14 fall
    por();
    repeat (16383) step();
    divClr = 1'b1; step(); divClr = 1'b0;
    check("R2 clear beats fall taps", int'(taps), 0);
    check("R2 clear suppresses wake", int'(wakePulse), 0);

    // R5/R6/R7: window of 8 falls of stage 4 -> edge 128
    wdRun(2'd0, 0, 0, 400, fe);
    check("R5 span0 fire edge", fe, 128);
    hiLen = 1;
    while (rstReq && hiLen < 20) begin
      step();
      if (rstReq) hiLen++;
    end
    check("R6 pulse length", hiLen, 4);
    check("R7 enable kept", int'(wdEn), 1);
    check("R7 flag set", int'(wdFlag), 1);
    repeat (123) step();
    check("R7 no second fire early", int'(rstReq), 0);
    step();
    check("R7 second fire at 256", int'(rstReq), 1);
    flagClr = 1'b1; step(); flagClr = 1'b0;
    check("R10 flag cleared", int'(wdFlag), 0);
    extRst = 1'b1; step(); extRst = 1'b0;
    check("R3 pin reset enable", int'(wdEn), 0);
    check("R3 pin reset pulse", int'(rstReq), 0);
    check("R3 pin reset upper", int'(taps[15:11]), 0);

    wdRun(2'd1, 0, 0, 1500, fe);
    check("R5 span1 fire edge", fe, 1024);
    wdRun(2'd2, 0, 0, 9000, fe);
    check("R5 span2 fire edge", fe, 8192);
    wdRun(2'd3, 0, 0, 9000, fe);
    check("R5 span3 fire edge", fe, 8192);

    // R8: kick on the terminal edge
    wdRun(2'd0, 128, 0, 400, fe);
    check("R8 kick beats terminal", fe, 256);

    // R9: disable mid-window
    wdRun(2'd0, 0, 64, 600, fe);
    check("R9 disabled no fire", fe, -1);
    check("R9 disabled flag", int'(wdEn), 0);
    wdEnSet = 1'b1; wdEnClr = 1'b1; step(); wdEnSet = 1'b0; wdEnClr = 1'b0;
    check("R9 clear wins", int'(wdEn), 0);
    wdEnSet = 1'b1; step(); wdEnSet = 1'b0;
    check("R9 set", int'(wdEn), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule